// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block merges a set of interrupt sources into one interrupt request for a CPU, together with the address the CPU should jump to. Every source has a pending flag, an unmask bit and a level bit. A mode bit picks between a single-level compatibility scheme, where all requests share one vector, and a two-level scheme, where each source is routed to a high or a low level and each level has its own vector.

The controller has two gate bits. One is the master enable, which also serves as the high-level enable. The other is the peripheral enable, which also serves as the low-level enable. When the master enable is 0, no request of any kind reaches the CPU. A low-level request needs both gate bits set. Software reaches the control, flag, unmask and level registers through a small synchronous bus. The CPU reports with an `ack` pulse when it takes an interrupt and with a `reti` pulse when it returns from one. The controller clears and then restores the matching gate bit, which allows a high-level request to preempt a low-level handler.

Top module: `icu_two_level`

## Requirements
- R1: After reset, all registers read 0, `irq_o` is 0 and `vec_o` is 0.
- R2: The bus decodes four registers. Address 0 is control, with bit 0 = master/high enable, bit 1 = peripheral/low enable and bit 2 = two-level mode. Address 1 is flags, address 2 is unmask bits and address 3 is level bits (1 = high). Source k uses bit k. A write takes effect at the next clock edge and reads are combinational.
- R3: In compatibility mode (bit 2 = 0) with the master enable set, any pending core source (flag and unmask both 1; sources 0 to 3 by default) raises `irq_o` with `lvl_o`=1 and `vec_o`=0x0008. The level bits are ignored in this mode.
- R4: In compatibility mode, a pending peripheral source (source 4 by default) also needs the peripheral enable before it raises `irq_o`.
- R5: In two-level mode, a pending source whose level bit is 1 raises `irq_o` with `lvl_o`=1 and `vec_o`=0x0008 when the master enable is 1.
- R6: In two-level mode, a pending source whose level bit is 0 raises `irq_o` with `lvl_o`=0 and `vec_o`=0x0018, but only when the low enable and the master enable are both 1.
- R7: While the master enable is 0, `irq_o` is 0 and `vec_o` is 0 in both modes, whatever the other bits hold.
- R8: When high-level and low-level requests are pending in the same cycle, the high level wins: `lvl_o`=1 and `vec_o`=0x0008.
- R9: A pulse on `evt_i[k]` sets flag k. The flag stays set until a bus write puts 0 in that bit. If an event and a clearing write arrive in the same cycle, the flag stays set.
- R10: A flag that is set while its source is masked stays pending. It raises `irq_o` once the unmask bit is written to 1.
- R11: An `ack_i` pulse while `irq_o`=1 and `lvl_o`=1 clears the master enable. An `ack_i` pulse while a low-level request is shown clears only the low enable, so a high-level request can still interrupt. An `ack_i` pulse while `irq_o`=0 has no effect.
- R12: A `reti_i` pulse sets the master enable again if a high-level interrupt is in service. Otherwise, if a low-level interrupt is in service, it sets the low enable again. Nested returns therefore restore the enables in the reverse order of their entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Bus write strobe |
| addr_i | input | 2 | Bus register address |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data (combinational) |
| evt_i | input | 5 | Per-source event pulses that set the flags |
| ack_i | input | 1 | CPU takes the interrupt that is shown |
| reti_i | input | 1 | CPU returns from the current handler |
| irq_o | output | 1 | Interrupt request to the CPU |
| lvl_o | output | 1 | Level of the request shown (1 = high) |
| vec_o | output | 16 | Vector address, 0 when there is no request |

## Verification
Every register change (a bus write, an event, an `ack_i` or a `reti_i`) takes effect at the next rising edge. `irq_o`, `lvl_o`, `vec_o` and `rdata_o` are combinational from those registers, so each result is due in the same cycle that follows that edge. The bench drives its stimulus on falling edges and samples on the next falling edge, half a period after the update and away from any active edge. A table of register settings covers the mode, gate and level combinations. Directed sequences then cover reset, flag stickiness, late unmasking and the nested ack/reti ordering, and check the enables again through the control register after each pulse.

// File: rtl/icu_pkg.sv
package icu_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_FLAG = 2'd1,
    REG_EN   = 2'd2,
    REG_PRIO = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic two_lvl;
    logic lo_en;
    logic hi_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = 3;
endpackage

// File: rtl/icu_src_regs.sv
module icu_src_regs #(
  parameter int unsigned N_SRC = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_flag_i,
  input  logic             wr_en_i,
  input  logic             wr_prio_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] evt_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] prio_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic flag_q, en_q, prio_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q <= 1'b0;
        en_q   <= 1'b0;
        prio_q <= 1'b0;
      end else begin
        // event set dominates a clearing write in the same cycle
        if (evt_i[k])       flag_q <= 1'b1;
        else if (wr_flag_i) flag_q <= wdata_i[k];
        if (wr_en_i)        en_q   <= wdata_i[k];
        if (wr_prio_i)      prio_q <= wdata_i[k];
      end
    end

    assign flag_o[k] = flag_q;
    assign en_o[k]   = en_q;
    assign prio_o[k] = prio_q;

    // R9
    evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> flag_o[k]);
  end

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_flag_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
endmodule

// File: rtl/icu_resolve.sv
module icu_resolve
  import icu_pkg::*;
#(
  parameter int unsigned       N_SRC     = 5,
  parameter logic [N_SRC-1:0]  CORE_MASK = 5'b01111
) (
  input  logic [N_SRC-1:0] flag_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] prio_i,
  input  ctrl_t            ctrl_i,
  output logic             hi_req_o,
  output logic             lo_req_o
);
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] compat_ok;
  logic             any_compat, any_hi, any_lo;

  assign pend = flag_i & en_i;

  // compatibility mode: peripheral sources need the peripheral gate
  for (genvar k = 0; k < N_SRC; k++) begin : g_gate
    if (CORE_MASK[k]) begin : g_core
      assign compat_ok[k] = pend[k];
    end else begin : g_periph
      assign compat_ok[k] = pend[k] & ctrl_i.lo_en;
    end
  end

  assign any_compat = |compat_ok;
  assign any_hi     = |(pend & prio_i);
  assign any_lo     = |(pend & ~prio_i);

  always_comb begin
    hi_req_o = 1'b0;
    lo_req_o = 1'b0;
    if (ctrl_i.hi_en) begin
      if (ctrl_i.two_lvl) begin
        hi_req_o = any_hi;
        lo_req_o = any_lo & ctrl_i.lo_en;
      end else begin
        hi_req_o = any_compat;
      end
    end
  end
endmodule

// File: rtl/icu_ctrl.sv
module icu_ctrl
  import icu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              take_hi_i,
  input  logic              take_lo_i,
  input  logic              reti_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  hi_act_q, hi_act_d;
  logic  lo_act_q, lo_act_d;

  always_comb begin
    ctrl_d   = ctrl_q;
    hi_act_d = hi_act_q;
    lo_act_d = lo_act_q;
    if (wr_ctrl_i) ctrl_d = ctrl_t'(wdata_i);
    if (reti_i) begin
      if (hi_act_q) begin
        ctrl_d.hi_en = 1'b1;
        hi_act_d     = 1'b0;
      end else if (lo_act_q) begin
        ctrl_d.lo_en = 1'b1;
        lo_act_d     = 1'b0;
      end
    end
    if (take_hi_i) begin
      ctrl_d.hi_en = 1'b0;
      hi_act_d     = 1'b1;
    end else if (take_lo_i) begin
      ctrl_d.lo_en = 1'b0;
      lo_act_d     = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      hi_act_q <= 1'b0;
      lo_act_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      hi_act_q <= hi_act_d;
      lo_act_q <= lo_act_d;
    end
  end

  assign ctrl_o = ctrl_q;

  // R11
  take_hi_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_hi_i |=> !ctrl_o.hi_en);

  // R11
  take_lo_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_lo_i && !wr_ctrl_i) |=> (!ctrl_o.lo_en && ctrl_o.hi_en == $past(ctrl_o.hi_en)));

  // R12
  reti_restores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && hi_act_q && !take_hi_i) |=> ctrl_o.hi_en);
endmodule

// File: rtl/icu_two_level.sv
module icu_two_level
  import icu_pkg::*;
#(
  parameter int unsigned      N_SRC     = 5,
  parameter int unsigned      DATA_W    = 8,
  parameter int unsigned      ADDR_W    = 2,
  parameter int unsigned      VEC_W     = 16,
  parameter logic [N_SRC-1:0] CORE_MASK = 5'b01111,
  parameter logic [VEC_W-1:0] VEC_HI    = 16'h0008,
  parameter logic [VEC_W-1:0] VEC_LO    = 16'h0018
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              irq_o,
  output logic              lvl_o,
  output logic [VEC_W-1:0]  vec_o
);
  reg_sel_e         sel;
  logic             wr_ctrl, wr_flag, wr_en, wr_prio;
  logic [N_SRC-1:0] flag, en, prio;
  ctrl_t            ctrl;
  logic             hi_req, lo_req;

  assign sel     = reg_sel_e'(addr_i[1:0]);
  assign wr_ctrl = we_i && (sel == REG_CTRL);
  assign wr_flag = we_i && (sel == REG_FLAG);
  assign wr_en   = we_i && (sel == REG_EN);
  assign wr_prio = we_i && (sel == REG_PRIO);

  icu_src_regs #(.N_SRC(N_SRC)) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_flag_i (wr_flag),
    .wr_en_i   (wr_en),
    .wr_prio_i (wr_prio),
    .wdata_i   (wdata_i[N_SRC-1:0]),
    .evt_i     (evt_i),
    .flag_o    (flag),
    .en_o      (en),
    .prio_o    (prio)
  );

  icu_resolve #(.N_SRC(N_SRC), .CORE_MASK(CORE_MASK)) u_res (
    .flag_i   (flag),
    .en_i     (en),
    .prio_i   (prio),
    .ctrl_i   (ctrl),
    .hi_req_o (hi_req),
    .lo_req_o (lo_req)
  );

  icu_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_ctrl),
    .wdata_i   (wdata_i[CTRL_W-1:0]),
    .take_hi_i (ack_i && hi_req),
    .take_lo_i (ack_i && !hi_req && lo_req),
    .reti_i    (reti_i),
    .ctrl_o    (ctrl)
  );

  assign irq_o = hi_req | lo_req;
  assign lvl_o = hi_req;

  always_comb begin
    vec_o = '0;
    if (hi_req)      vec_o = VEC_HI;
    else if (lo_req) vec_o = VEC_LO;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_CTRL: rdata_o = DATA_W'(ctrl);
      REG_FLAG: rdata_o = DATA_W'(flag);
      REG_EN:   rdata_o = DATA_W'(en);
      REG_PRIO: rdata_o = DATA_W'(prio);
      default:  rdata_o = '0;
    endcase
  end

  // R7
  master_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.hi_en |-> (!irq_o && vec_o == '0));

  // R5
  hi_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && lvl_o) |-> (vec_o == VEC_HI));

  // R6
  lo_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !lvl_o) |-> (ctrl.two_lvl && ctrl.lo_en && ctrl.hi_en && vec_o == VEC_LO));

  // R10
  pend_needs_unmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flag & en) != '0));
endmodule

// File: tb/tb_icu_two_level.sv
module tb_icu_two_level;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;
  // {ctrl[2:0], flag[4:0], en[4:0], prio[4:0], exp_irq, exp_lvl}
  localparam logic [19:0] VECS [N] = '{
    {3'b001, 5'b00001, 5'b00001, 5'b00000, 1'b1, 1'b1}, // R3
    {3'b001, 5'b10000, 5'b10000, 5'b00000, 1'b0, 1'b0}, // R4
    {3'b011, 5'b10000, 5'b10000, 5'b00000, 1'b1, 1'b1}, // R4
    {3'b001, 5'b00100, 5'b00100, 5'b00000, 1'b1, 1'b1}, // R3 prio ignored
    {3'b000, 5'b11111, 5'b11111, 5'b00000, 1'b0, 1'b0}, // R7
    {3'b101, 5'b00010, 5'b00010, 5'b00010, 1'b1, 1'b1}, // R5
    {3'b101, 5'b00010, 5'b00010, 5'b00000, 1'b0, 1'b0}, // R6
    {3'b111, 5'b00010, 5'b00010, 5'b00000, 1'b1, 1'b0}, // R6
    {3'b110, 5'b00010, 5'b00010, 5'b00000, 1'b0, 1'b0}, // R7
    {3'b111, 5'b00011, 5'b00011, 5'b00001, 1'b1, 1'b1}, // R8
    {3'b111, 5'b01000, 5'b00000, 5'b00000, 1'b0, 1'b0}, // R10
    {3'b100, 5'b11111, 5'b11111, 5'b10101, 1'b0, 1'b0}  // R7
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [4:0]  evt_i = '0;
  logic        ack_i = 1'b0;
  logic        reti_i = 1'b0;
  logic        irq_o, lvl_o;
  logic [15:0] vec_o;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  icu_two_level dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse_ack();
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0;
  endtask

  task automatic pulse_reti();
    @(negedge clk_i); reti_i = 1'b1;
    @(negedge clk_i); reti_i = 1'b0;
  endtask

  function automatic logic [17:0] outs(logic irq, logic lvl);
    logic [15:0] v;
    v = !irq ? 16'h0 : (lvl ? 16'h0008 : 16'h0018);
    return {irq, lvl, v};
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 irq/vec", {14'b0, irq_o, lvl_o, vec_o}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reg", d, 8'h0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", {14'b0, irq_o, lvl_o, vec_o}, 32'h0);

    // table walk
    for (int i = 0; i < N; i++) begin
      wr(2'd0, 8'h00);
      wr(2'd3, {3'b0, VECS[i][6:2]});
      wr(2'd2, {3'b0, VECS[i][11:7]});
      wr(2'd1, {3'b0, VECS[i][16:12]});
      wr(2'd0, {5'b0, VECS[i][19:17]});
      check($sformatf("R3-R8 table row %0d", i), {14'b0, irq_o, lvl_o, vec_o},
            {14'b0, outs(VECS[i][1], VECS[i][0])});
      rd(2'd0, d);
      check("R2 ctrl readback", d, {5'b0, VECS[i][19:17]});
    end

    // R9 event sets flag, sticky until write 0
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    @(negedge clk_i); evt_i = 5'b01000;
    @(negedge clk_i); evt_i = '0;
    repeat (3) @(negedge clk_i);
    rd(2'd1, d);
    check("R9 flag held", d, 8'h08);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 2'd1; wdata_i = 8'h00; evt_i = 5'b01000;
    @(negedge clk_i);
    we_i = 1'b0; evt_i = '0;
    rd(2'd1, d);
    check("R9 event beats clear", d, 8'h08);
    wr(2'd1, 8'h00);
    rd(2'd1, d);
    check("R9 write 0 clears", d, 8'h00);

    // R10 masked flag stays pending
    wr(2'd0, 8'h03);
    @(negedge clk_i); evt_i = 5'b00100;
    @(negedge clk_i); evt_i = '0;
    check("R10 masked no irq", {31'b0, irq_o}, 32'h0);
    wr(2'd2, 8'h04);
    check("R10 unmask raises", {14'b0, irq_o, lvl_o, vec_o}, {14'b0, outs(1'b1, 1'b1)});

    // R11/R12 nested ack/reti in two-level mode
    wr(2'd1, 8'h00); wr(2'd2, 8'h03); wr(2'd3, 8'h01);
    wr(2'd1, 8'h02); wr(2'd0, 8'h07);
    check("R6 low shown", {14'b0, irq_o, lvl_o, vec_o}, {14'b0, outs(1'b1, 1'b0)});
    pulse_ack();
    rd(2'd0, d);
    check("R11 low ack clears low only", d, 8'h05);
    check("R11 low masked", {31'b0, irq_o}, 32'h0);
    wr(2'd1, 8'h03);
    check("R11 high preempts", {14'b0, irq_o, lvl_o, vec_o}, {14'b0, outs(1'b1, 1'b1)});
    pulse_ack();
    rd(2'd0, d);
    check("R11 high ack clears master", d, 8'h04);
    pulse_ack();
    rd(2'd0, d);
    check("R11 ack idle ignored", d, 8'h04);
    wr(2'd1, 8'h02);
    pulse_reti();
    rd(2'd0, d);
    check("R12 reti restores master", d, 8'h05);
    check("R12 low still masked", {31'b0, irq_o}, 32'h0);
    pulse_reti();
    rd(2'd0, d);
    check("R12 reti restores low", d, 8'h07);
    check("R12 low shown again", {14'b0, irq_o, lvl_o, vec_o}, {14'b0, outs(1'b1, 1'b0)});

    // R11/R12 compatibility mode
    wr(2'd0, 8'h01);
    pulse_ack();
    rd(2'd0, d);
    check("R11 compat ack", d, 8'h00);
    pulse_reti();
    rd(2'd0, d);
    check("R12 compat reti", d, 8'h01);

    finish_run();
  end
endmodule